// File: doc/BRIEF.md
# Eight-Pixel Colour Match Unit

This block takes one byte from each of three colour planes (blue, red, green) and treats each bit position as one pixel. It builds a 3-bit colour per pixel and tests it against up to eight reference colours. The result is an 8-bit status byte with one bit per pixel. A status bit is set when that pixel's colour equals at least one valid reference.

A plane-disable mask removes planes from the comparison. A disabled plane is ignored on the pixel side and on the reference side alike. Each reference byte has an invalid flag in its top bit, and an invalid reference never produces a match.

A one-cycle start strobe begins a comparison. The status clears on the next edge. The result and a one-cycle done pulse appear one edge after that. The status then holds its value until the next accepted start.

Top module: `pix_cmp_unit`

## Requirements
- R1: After reset, `status_o` is 0x00 and `done_o` is 0.
- R2: Pixel k takes its colour from plane bit k as {green[k], red[k], blue[k]}, with blue in colour bit 0, red in colour bit 1 and green in colour bit 2. Its result lands in `status_o[k]`, so the leftmost pixel (plane bit 7) maps to status bit 7.
- R3: `status_o[k]` is 1 exactly when the masked colour of pixel k equals the masked colour (bits 2:0) of at least one valid reference.
- R4: Reference j occupies `refs_i[8*j+7:8*j]`. It is invalid, and never matches, when its bit 7 is 1. Its bits 6:3 have no effect.
- R5: Both colours are ANDed with the inverse of `plane_off_i[2:0]` before the compare. Bits 7:3 of `plane_off_i` have no effect. With all three planes off, every pixel matches whenever one valid reference exists.
- R6: On the edge that accepts a start, `status_o` clears to 0x00. On the following edge it takes the result, and `done_o` is high for exactly that one cycle.
- R7: A start that arrives while a comparison is in flight (the cycle after an accepted start) is ignored and does not disturb the pending result.
- R8: Apart from the clear and the result load, `status_o` holds its value.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a comparison |
| blue_i | input | 8 | Blue plane byte |
| red_i | input | 8 | Red plane byte |
| green_i | input | 8 | Green plane byte |
| refs_i | input | 64 | Eight reference bytes, reference j at bits 8j+7:8j |
| plane_off_i | input | 8 | Plane-disable mask, bits 2:0 used |
| status_o | output | 8 | Per-pixel match status |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The tests use several input patterns:
- A single valid reference against mixed pixels, which separates matches from misses.
- Pixels that differ in only one plane, which expose a swapped plane-to-colour-bit mapping.
- A lone distinct leftmost pixel, which exposes a reversed status order.
- All references invalid, or references whose junk bits 6:3 are set, which test the valid flag and the 3-bit compare.

Partial and full plane-disable masks, including high junk bits in the mask, separate two-sided masking from one-sided masking. Back-to-back start strobes show that a busy-time start is dropped. The status is also checked at the clear cycle and in the hold cycle after done.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int COLW = 3;

  // Colour of pixel k built from the three plane bytes.
  function automatic logic [COLW-1:0] pick_colour(input logic [7:0] b,
                                                  input logic [7:0] r,
                                                  input logic [7:0] g,
                                                  input int k);
    return {g[k], r[k], b[k]};
  endfunction

  // Planes that take part in the compare.
  function automatic logic [COLW-1:0] keep_mask(input logic [7:0] off);
    return ~off[COLW-1:0];
  endfunction

  // A reference byte counts only with its top bit clear.
  function automatic logic ref_valid(input logic [7:0] rb);
    return ~rb[7];
  endfunction
endpackage

// File: rtl/pcu_ref_stage.sv
module pcu_ref_stage
  import pcu_pkg::*;
#(
  parameter int NREF = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NREF*8-1:0]    refs,
  input  logic [COLW-1:0]      keep,
  output logic [NREF*COLW-1:0] ref_col,
  output logic [NREF-1:0]      ref_ok
);
  for (genvar j = 0; j < NREF; j++) begin : g_ref
    logic [7:0] rb;
    assign rb = refs[8*j +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_col[COLW*j +: COLW] <= '0;
        ref_ok[j]               <= 1'b0;
      end else if (load) begin
        ref_col[COLW*j +: COLW] <= rb[COLW-1:0] & keep;
        ref_ok[j]               <= ref_valid(rb);
      end
    end
  end
endmodule

// File: rtl/pcu_pix_stage.sv
module pcu_pix_stage
  import pcu_pkg::*;
#(
  parameter int NPIX = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [7:0]           blu,
  input  logic [7:0]           red,
  input  logic [7:0]           grn,
  input  logic [COLW-1:0]      keep,
  output logic [NPIX*COLW-1:0] pix_col
);
  for (genvar k = 0; k < NPIX; k++) begin : g_pix
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pix_col[COLW*k +: COLW] <= '0;
      else if (load)
        pix_col[COLW*k +: COLW] <= pick_colour(blu, red, grn, k) & keep;
    end
  end
endmodule

// File: rtl/pcu_match.sv
module pcu_match
  import pcu_pkg::*;
#(
  parameter int NPIX = 8,
  parameter int NREF = 8
) (
  input  logic [NPIX*COLW-1:0] pix_col,
  input  logic [NREF*COLW-1:0] ref_col,
  input  logic [NREF-1:0]      ref_ok,
  output logic [NPIX-1:0]      hit
);
  for (genvar k = 0; k < NPIX; k++) begin : g_p
    logic [NREF-1:0] eq;
    for (genvar j = 0; j < NREF; j++) begin : g_r
      assign eq[j] = ref_ok[j] && (pix_col[COLW*k +: COLW] == ref_col[COLW*j +: COLW]);
    end
    assign hit[k] = |eq;
  end
endmodule

// File: rtl/pix_cmp_unit.sv
module pix_cmp_unit
  import pcu_pkg::*;
#(
  parameter int NPIX = 8,
  parameter int NREF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        blue_i,
  input  logic [7:0]        red_i,
  input  logic [7:0]        green_i,
  input  logic [NREF*8-1:0] refs_i,
  input  logic [7:0]        plane_off_i,
  output logic [NPIX-1:0]   status_o,
  output logic              done_o
);
  logic                 busy_q;
  logic                 start_accept;
  logic [COLW-1:0]      keep;
  logic [NREF*COLW-1:0] ref_col;
  logic [NREF-1:0]      ref_ok;
  logic [NPIX*COLW-1:0] pix_col;
  logic [NPIX-1:0]      hit;

  assign keep         = keep_mask(plane_off_i);
  assign start_accept = start_i && !busy_q;

  pcu_ref_stage #(.NREF(NREF)) u_ref (
    .clk(clk), .rst_n(rst_n), .load(start_accept), .refs(refs_i),
    .keep(keep), .ref_col(ref_col), .ref_ok(ref_ok)
  );

  pcu_pix_stage #(.NPIX(NPIX)) u_pix (
    .clk(clk), .rst_n(rst_n), .load(start_accept), .blu(blue_i),
    .red(red_i), .grn(green_i), .keep(keep), .pix_col(pix_col)
  );

  pcu_match #(.NPIX(NPIX), .NREF(NREF)) u_match (
    .pix_col(pix_col), .ref_col(ref_col), .ref_ok(ref_ok), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_o   <= 1'b0;
      status_o <= '0;
    end else begin
      busy_q <= start_accept;
      done_o <= busy_q;
      if (busy_q)
        status_o <= hit;
      else if (start_accept)
        status_o <= '0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (status_o == '0 && !done_o)); // R1
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> status_o == '0); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(start_accept, 2)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start_accept); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_accept && !busy_q) |=> $stable(status_o)); // R8
  AST_NO_VALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ref_ok == '0) |=> status_o == '0); // R4
endmodule

// File: tb/pix_cmp_unit_tb.sv
module pix_cmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  blue_i = '0, red_i = '0, green_i = '0, plane_off_i = '0;
  logic [63:0] refs_i = {8{8'h80}};
  logic [7:0]  status_o;
  logic        done_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pix_cmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blue_i(blue_i),
    .red_i(red_i), .green_i(green_i), .refs_i(refs_i),
    .plane_off_i(plane_off_i), .status_o(status_o), .done_o(done_o)
  );

  function automatic logic [7:0] model(input logic [7:0] b, input logic [7:0] r,
                                       input logic [7:0] g, input logic [63:0] rf,
                                       input logic [7:0] off);
    logic [7:0] res = '0;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] pc;
      pc = {g[k], r[k], b[k]};
      for (int j = 0; j < 8; j++) begin
        logic [7:0] rb;
        rb = rf[8*j +: 8];
        if (rb[7] == 1'b0 && ((pc ^ rb[2:0]) & ~off[2:0]) == 3'b000) res[k] = 1'b1;
      end
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs one comparison; checks clear, result, done pulse and hold.
  task automatic run(input string req, input logic [7:0] b, input logic [7:0] r,
                     input logic [7:0] g, input logic [63:0] rf, input logic [7:0] off);
    logic [7:0] exp;
    exp = model(b, r, g, rf, off);
    @(negedge clk);
    blue_i = b; red_i = r; green_i = g; refs_i = rf; plane_off_i = off; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({req, " R6 clear"}, status_o, 8'h00);
    check({req, " R6 done low"}, {7'd0, done_o}, 8'd0);
    @(negedge clk);
    check({req, " R6 done"}, {7'd0, done_o}, 8'd1);
    check(req, status_o, exp);
    @(negedge clk);
    check({req, " R6 done single"}, {7'd0, done_o}, 8'd0);
    check({req, " R8 hold"}, status_o, exp);
  endtask

  task automatic t_reset();
    check("R1 status", status_o, 8'h00);
    check("R1 done", {7'd0, done_o}, 8'd0);
  endtask

  task automatic t_basic();
    // ref0 = colour 5 (green+blue); pixels 7 and 0 are colour 5
    run("R3 basic", 8'h81, 8'h00, 8'h81, {{7{8'h80}}, 8'h05}, 8'h00);
    check("R3 basic literal", status_o, 8'h81);
    run("R3 multi", 8'hF0, 8'hCC, 8'hAA, {{5{8'h80}}, 8'h07, 8'h02, 8'h04}, 8'h00);
  endtask

  task automatic t_order();
    // only pixel at plane bit 7 is red (colour 2); ref = 2
    run("R2 order", 8'h00, 8'h80, 8'h00, {{7{8'h80}}, 8'h02}, 8'h00);
    check("R2 order literal", status_o, 8'h80);
    // blue-only pixel at bit 3 vs red reference: must not match
    run("R2 plane map", 8'h08, 8'h00, 8'hF7, {{7{8'h80}}, 8'h02}, 8'h00);
    check("R2 plane map literal", status_o, 8'h00);
  endtask

  task automatic t_valid();
    run("R4 none valid", 8'hFF, 8'h00, 8'h55, {8{8'h81}}, 8'h00);
    check("R4 none literal", status_o, 8'h00);
    // junk bits 6:3 set, low bits colour 1
    run("R4 junk bits", 8'h0F, 8'h00, 8'h00, {{7{8'h80}}, 8'h79}, 8'h00);
    check("R4 junk literal", status_o, 8'h0F);
  endtask

  task automatic t_disable();
    // green disabled: pixel colour 5 matches ref 1
    run("R5 partial", 8'hFF, 8'h00, 8'h0F, {{7{8'h80}}, 8'h01}, 8'h04);
    check("R5 partial literal", status_o, 8'hFF);
    run("R5 all off", 8'h12, 8'h34, 8'h56, {{7{8'h80}}, 8'h06}, 8'h07);
    check("R5 all off literal", status_o, 8'hFF);
    run("R5 high bits", 8'hF0, 8'h00, 8'h00, {{7{8'h80}}, 8'h01}, 8'hF8);
    check("R5 high bits literal", status_o, 8'hF0);
  endtask

  task automatic t_busy();
    logic [7:0] exp;
    exp = model(8'hAA, 8'h00, 8'h00, {{7{8'h80}}, 8'h01}, 8'h00);
    @(negedge clk);
    blue_i = 8'hAA; red_i = '0; green_i = '0; refs_i = {{7{8'h80}}, 8'h01};
    plane_off_i = '0; start_i = 1'b1;
    @(negedge clk);
    blue_i = 8'h55;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 first result", status_o, exp);
    check("R7 done", {7'd0, done_o}, 8'd1);
    @(negedge clk);
    check("R7 dropped start", {7'd0, done_o}, 8'd0);
    check("R7 status kept", status_o, exp);
    @(negedge clk);
    check("R7 still kept", status_o, exp);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_valid();
    t_disable();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule